// File: doc/BRIEF.md
# Almost-Full Throttled Request Issuer

The block sits between internal request producers and a downstream port with two outbound request channels. Read requests go out on the read channel as a header alone. Write requests go out on the write channel as a header and a 512-bit data word in the same beat. Each channel holds its own small pending queue, which producers fill through a valid/ready handshake. Each channel also has its own issue budget and its own registered output stage.

The downstream port does not use a ready signal. Instead it raises an almost-full input for each channel. Once a channel's almost-full input is high, only a fixed number of further requests may be sent on that channel, and then the channel must stop. When the input drops, sending may resume in the very next cycle. The two channels are throttled entirely apart from each other. A parameter can make the block stricter than the port allows, so that it stops after fewer than eight requests.

Top module: `throttled_req_issuer`

## Requirements
- R1: A read request carries a 74-bit header, which appears on `rd_out_hdr` together with a one-cycle pulse on `rd_out_valid`.
- R2: A write request carries an 80-bit header and a 512-bit data word. Both appear in the same beat and are qualified by the single `wr_out_valid`.
- R3: A request counts against the budget when it is issued at a clock edge where the channel's almost-full input is high. Between two edges where almost-full is low, a channel issues at most LIMIT such requests. LIMIT is never more than 8.
- R4: At a clock edge where a channel's almost-full input is low and its queue holds an entry, that channel issues. Its valid output is high in the following cycle.
- R5: Requests leave each channel in the order in which they were accepted, one valid pulse per request. A request accepted at edge k can be issued at edge k+1 at the earliest, with no bypass of the queue.
- R6: While a channel's valid output is low, its header (and data, for writes) keep the values of the last issued request. After reset they are zero.
- R7: `rd_in_ready` and `wr_in_ready` are high exactly when that channel's queue has a free slot and the channel is allowed to issue in this cycle. A channel is allowed to issue when its almost-full input is low or its budget is not used up.
- R8: A channel's budget refills completely at any edge where its almost-full input is low. Almost-full on one channel has no effect on the other channel.
- R9: The LIMIT parameter sets the budget. Its default is 8, and values above 8 are clamped to 8. With LIMIT = 3, a channel stops after three requests under almost-full.
- R10: Each pending queue holds DEPTH requests. After reset both queues are empty, both valid outputs are low and both budgets are full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_in_valid | input | 1 | Producer offers a read request |
| rd_in_ready | output | 1 | Read queue accepts this cycle |
| rd_in_hdr | input | RD_HDR_W (74) | Read request header from producer |
| wr_in_valid | input | 1 | Producer offers a write request |
| wr_in_ready | output | 1 | Write queue accepts this cycle |
| wr_in_hdr | input | WR_HDR_W (80) | Write request header from producer |
| wr_in_data | input | WR_DATA_W (512) | Write data from producer |
| rd_almost_full | input | 1 | Downstream read channel nearly full |
| wr_almost_full | input | 1 | Downstream write channel nearly full |
| rd_out_valid | output | 1 | Read header valid this cycle |
| rd_out_hdr | output | RD_HDR_W (74) | Issued read header |
| wr_out_valid | output | 1 | Write header and data valid this cycle |
| wr_out_hdr | output | WR_HDR_W (80) | Issued write header |
| wr_out_data | output | WR_DATA_W (512) | Issued write data |

## Verification
The ready outputs are combinational from the almost-full inputs and the registered state. The bench therefore checks them one time step after it drives new inputs, in the same cycle. An issue decision made at an edge shows on the valid and payload outputs in the cycle that edge starts, so the bench predicts each channel's output from its own model of queue occupancy and budget before the edge, and compares at the next falling edge. Both a default instance and a LIMIT = 3 instance run through phases of fast almost-full toggling, long high runs, short low blips, and a split where one channel is throttled while the other is free. A drain at the end confirms that every queued request came out in order.

// File: rtl/issuer_pkg.sv
package issuer_pkg;

  // Further requests the downstream port tolerates after almost-full rises.
  localparam int unsigned ALLOWANCE = 8;

  // Budget requested by a parameter, kept inside 1..ALLOWANCE.
  function automatic int unsigned clamp_limit(int unsigned req);
    if (req > ALLOWANCE) return ALLOWANCE;
    if (req == 0)        return 1;
    return req;
  endfunction

  // A channel may issue when the port is not nearly full or budget remains.
  function automatic logic budget_open(int unsigned used, logic af, int unsigned limit);
    return (!af) || (used < limit);
  endfunction

  // Budget use after an edge: refilled when almost-full is low.
  function automatic int unsigned budget_next(int unsigned used, logic af, logic fired);
    if (!af)   return 0;
    if (fired) return used + 1;
    return used;
  endfunction

  // Ring pointer advance for a queue of any depth.
  function automatic int unsigned ring_next(int unsigned ptr, int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/req_fifo.sv
module req_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [OW-1:0] occ;

  assign empty = (occ == '0);
  assign full  = (occ == OW'(DEPTH));
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= PW'(issuer_pkg::ring_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(issuer_pkg::ring_next(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/issue_budget.sv
module issue_budget #(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          almost_full,
  input  logic          fired,
  output logic          open,
  output logic [CW-1:0] used
);
  logic [CW-1:0] used_q;

  assign used = used_q;
  assign open = issuer_pkg::budget_open(int'(used_q), almost_full, LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= CW'(issuer_pkg::budget_next(int'(used_q), almost_full, fired));
  end
endmodule

// File: rtl/chan_issuer.sv
module chan_issuer #(
  parameter int unsigned W     = 74,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_payload,
  input  logic          almost_full,
  output logic          out_valid,
  output logic [W-1:0]  out_payload,
  output logic          issue,
  output logic          pending,
  output logic          budget_ok,
  output logic [CW-1:0] budget_used
);
  logic         q_empty, q_full, q_push;
  logic [W-1:0] q_head;

  assign pending  = !q_empty;
  assign issue    = pending && budget_ok;
  assign in_ready = !q_full && budget_ok;
  assign q_push   = in_valid && in_ready;

  req_fifo #(.W(W), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .wdata (in_payload),
    .pop   (issue),
    .rdata (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  issue_budget #(.LIMIT(LIMIT)) u_budget (
    .clk         (clk),
    .rst_n       (rst_n),
    .almost_full (almost_full),
    .fired       (issue),
    .open        (budget_ok),
    .used        (budget_used)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_payload <= '0;
    end else begin
      out_valid <= issue;
      if (issue) out_payload <= q_head;
    end
  end
endmodule

// File: rtl/throttled_req_issuer.sv
module throttled_req_issuer #(
  parameter int unsigned RD_HDR_W  = 74,
  parameter int unsigned WR_HDR_W  = 80,
  parameter int unsigned WR_DATA_W = 512,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned LIMIT     = issuer_pkg::ALLOWANCE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_in_valid,
  output logic                 rd_in_ready,
  input  logic [RD_HDR_W-1:0]  rd_in_hdr,
  input  logic                 wr_in_valid,
  output logic                 wr_in_ready,
  input  logic [WR_HDR_W-1:0]  wr_in_hdr,
  input  logic [WR_DATA_W-1:0] wr_in_data,
  input  logic                 rd_almost_full,
  input  logic                 wr_almost_full,
  output logic                 rd_out_valid,
  output logic [RD_HDR_W-1:0]  rd_out_hdr,
  output logic                 wr_out_valid,
  output logic [WR_HDR_W-1:0]  wr_out_hdr,
  output logic [WR_DATA_W-1:0] wr_out_data
);
  localparam int unsigned EFF_LIMIT = issuer_pkg::clamp_limit(LIMIT);
  localparam int unsigned CNT_W     = $clog2(EFF_LIMIT + 1);
  localparam int unsigned WR_W      = WR_HDR_W + WR_DATA_W;

  // Named internal events, brought out for the checker.
  logic             rd_issue, rd_pending, rd_open;
  logic             wr_issue, wr_pending, wr_open;
  logic [CNT_W-1:0] rd_used, wr_used;
  logic [WR_W-1:0]  wr_out_beat;

  chan_issuer #(.W(RD_HDR_W), .DEPTH(DEPTH), .LIMIT(EFF_LIMIT)) u_rd_chan (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (rd_in_valid),
    .in_ready    (rd_in_ready),
    .in_payload  (rd_in_hdr),
    .almost_full (rd_almost_full),
    .out_valid   (rd_out_valid),
    .out_payload (rd_out_hdr),
    .issue       (rd_issue),
    .pending     (rd_pending),
    .budget_ok   (rd_open),
    .budget_used (rd_used)
  );

  chan_issuer #(.W(WR_W), .DEPTH(DEPTH), .LIMIT(EFF_LIMIT)) u_wr_chan (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (wr_in_valid),
    .in_ready    (wr_in_ready),
    .in_payload  ({wr_in_hdr, wr_in_data}),
    .almost_full (wr_almost_full),
    .out_valid   (wr_out_valid),
    .out_payload (wr_out_beat),
    .issue       (wr_issue),
    .pending     (wr_pending),
    .budget_ok   (wr_open),
    .budget_used (wr_used)
  );

  assign wr_out_hdr  = wr_out_beat[WR_W-1:WR_DATA_W];
  assign wr_out_data = wr_out_beat[WR_DATA_W-1:0];
endmodule

// File: rtl/issuer_sva.sv
module issuer_sva #(
  parameter int unsigned LIMIT     = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned RD_HDR_W  = 74,
  parameter int unsigned WR_HDR_W  = 80,
  parameter int unsigned WR_DATA_W = 512
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_almost_full,
  input logic                 wr_almost_full,
  input logic                 rd_issue,
  input logic                 wr_issue,
  input logic                 rd_pending,
  input logic                 wr_pending,
  input logic [CNT_W-1:0]     rd_used,
  input logic [CNT_W-1:0]     wr_used,
  input logic                 rd_in_ready,
  input logic                 wr_in_ready,
  input logic                 rd_out_valid,
  input logic                 wr_out_valid,
  input logic [RD_HDR_W-1:0]  rd_out_hdr,
  input logic [WR_HDR_W-1:0]  wr_out_hdr,
  input logic [WR_DATA_W-1:0] wr_out_data
);
  AST_RD_ALLOWANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_almost_full && rd_used == CNT_W'(LIMIT)) |-> !rd_issue); // R3
  AST_WR_ALLOWANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_almost_full && wr_used == CNT_W'(LIMIT)) |-> !wr_issue); // R3
  AST_RD_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_almost_full && rd_pending) |=> rd_out_valid); // R4
  AST_WR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_almost_full && wr_pending) |=> wr_out_valid); // R4
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_issue |=> !rd_out_valid); // R5
  AST_WR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_issue |=> !wr_out_valid); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_out_valid |-> $stable(rd_out_hdr)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out_valid |-> ($stable(wr_out_hdr) && $stable(wr_out_data))); // R6
  AST_RD_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_almost_full && rd_used == CNT_W'(LIMIT)) |-> !rd_in_ready); // R7
  AST_WR_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_almost_full && wr_used == CNT_W'(LIMIT)) |-> !wr_in_ready); // R7
  AST_RD_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_almost_full |=> (rd_used == '0)); // R8
  AST_WR_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_almost_full |=> (wr_used == '0)); // R8
endmodule

bind throttled_req_issuer issuer_sva #(
  .LIMIT(EFF_LIMIT), .CNT_W(CNT_W),
  .RD_HDR_W(RD_HDR_W), .WR_HDR_W(WR_HDR_W), .WR_DATA_W(WR_DATA_W)
) u_issuer_sva (
  .clk(clk), .rst_n(rst_n),
  .rd_almost_full(rd_almost_full), .wr_almost_full(wr_almost_full),
  .rd_issue(rd_issue), .wr_issue(wr_issue),
  .rd_pending(rd_pending), .wr_pending(wr_pending),
  .rd_used(rd_used), .wr_used(wr_used),
  .rd_in_ready(rd_in_ready), .wr_in_ready(wr_in_ready),
  .rd_out_valid(rd_out_valid), .wr_out_valid(wr_out_valid),
  .rd_out_hdr(rd_out_hdr), .wr_out_hdr(wr_out_hdr), .wr_out_data(wr_out_data)
);

// File: tb/throttled_req_issuer_bench.sv
module throttled_req_issuer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int STRICT     = 3;
  localparam int CYCLES     = 4000;
  localparam int PW         = 592;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Streams: 0 read/default, 1 write/default, 2 read/strict, 3 write/strict.
  logic [3:0]    af  = '0;
  logic [3:0]    inv = '0;
  logic [PW-1:0] in_pl [4];

  logic          rdy_a_r, rdy_a_w, rdy_b_r, rdy_b_w;
  logic          v_a_r, v_a_w, v_b_r, v_b_w;
  logic [73:0]   h_a_r, h_b_r;
  logic [79:0]   h_a_w, h_b_w;
  logic [511:0]  d_a_w, d_b_w;

  throttled_req_issuer u_throttled_req_issuer (
    .clk(clk), .rst_n(rst_n),
    .rd_in_valid(inv[0]), .rd_in_ready(rdy_a_r), .rd_in_hdr(in_pl[0][73:0]),
    .wr_in_valid(inv[1]), .wr_in_ready(rdy_a_w),
    .wr_in_hdr(in_pl[1][591:512]), .wr_in_data(in_pl[1][511:0]),
    .rd_almost_full(af[0]), .wr_almost_full(af[1]),
    .rd_out_valid(v_a_r), .rd_out_hdr(h_a_r),
    .wr_out_valid(v_a_w), .wr_out_hdr(h_a_w), .wr_out_data(d_a_w)
  );

  throttled_req_issuer #(.LIMIT(STRICT)) u_throttled_req_issuer_strict (
    .clk(clk), .rst_n(rst_n),
    .rd_in_valid(inv[2]), .rd_in_ready(rdy_b_r), .rd_in_hdr(in_pl[2][73:0]),
    .wr_in_valid(inv[3]), .wr_in_ready(rdy_b_w),
    .wr_in_hdr(in_pl[3][591:512]), .wr_in_data(in_pl[3][511:0]),
    .rd_almost_full(af[2]), .wr_almost_full(af[3]),
    .rd_out_valid(v_b_r), .rd_out_hdr(h_b_r),
    .wr_out_valid(v_b_w), .wr_out_hdr(h_b_w), .wr_out_data(d_b_w)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  function automatic logic [PW-1:0] obs_pl(int s);
    case (s)
      0: return {518'b0, h_a_r};
      1: return {h_a_w, d_a_w};
      2: return {518'b0, h_b_r};
      default: return {h_b_w, d_b_w};
    endcase
  endfunction

  function automatic logic obs_v(int s);
    case (s)
      0: return v_a_r;
      1: return v_a_w;
      2: return v_b_r;
      default: return v_b_w;
    endcase
  endfunction

  function automatic logic obs_rdy(int s);
    case (s)
      0: return rdy_a_r;
      1: return rdy_a_w;
      2: return rdy_b_r;
      default: return rdy_b_w;
    endcase
  endfunction

  function automatic logic [PW-1:0] rand_pl(int s);
    logic [PW-1:0] v = '0;
    for (int k = 0; k < PW / 32 + 1; k++) v = {v[PW-33:0], 32'($urandom)};
    if (s % 2 == 0) v = {518'b0, v[73:0]};
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model state.
  logic [PW-1:0] mq   [4][DEPTH];
  int            head [4];
  int            occ  [4];
  int            used [4];
  logic [PW-1:0] last [4];
  bit            exp_v [4];
  string         v_tag [4];

  function automatic int lim(int s);
    return (s < 2) ? 8 : STRICT;
  endfunction

  task automatic compare_outputs();
    for (int s = 0; s < 4; s++) begin
      check(obs_v(s) == exp_v[s], v_tag[s], $sformatf("valid s%0d", s),
            PW'(obs_v(s)), PW'(exp_v[s]));
      // R1 R2 R6: issued payload, or held value while idle
      check(obs_pl(s) == last[s], (s % 2 == 0) ? "R1/R6" : "R2/R6",
            $sformatf("payload s%0d", s), obs_pl(s), last[s]);
    end
  endtask

  task automatic step_model();
    for (int s = 0; s < 4; s++) begin
      bit can, rdy, push, iss;
      can  = !af[s] || (used[s] < lim(s));
      rdy  = (occ[s] < DEPTH) && can;
      // R7: ready follows queue room and issue permission
      check(obs_rdy(s) == rdy, "R7", $sformatf("ready s%0d", s), PW'(obs_rdy(s)), PW'(rdy));
      push = inv[s] && rdy;
      iss  = (occ[s] > 0) && can;
      exp_v[s] = iss;
      if (iss)                           v_tag[s] = af[s] ? "R3" : "R4";
      else if (occ[s] > 0)               v_tag[s] = (s < 2) ? "R3" : "R9";
      else                               v_tag[s] = "R5";
      if (iss) begin
        last[s] = mq[s][head[s]];
        head[s] = (head[s] + 1) % DEPTH;
        occ[s]--;
      end
      if (push) begin
        mq[s][(head[s] + occ[s]) % DEPTH] = in_pl[s];
        occ[s]++;
      end
      if (!af[s])   used[s] = 0;
      else if (iss) used[s]++;
      // R3 R9: budget use since almost-full rose stays inside the allowance
      check(used[s] <= lim(s) && used[s] <= 8, (s < 2) ? "R3" : "R9",
            $sformatf("budget s%0d", s), PW'(used[s]), PW'(lim(s)));
    end
  endtask

  task automatic drive(int phase);
    for (int s = 0; s < 4; s++) begin
      case (phase)
        0: af[s] = 1'($urandom % 2);
        1: if ($urandom % 20 == 0) af[s] = ~af[s];
        2: af[s] = ($urandom % 12) != 0;
        3: af[s] = (s % 2 == 0);     // R8: reads throttled, writes free
        default: af[s] = 1'b0;
      endcase
      inv[s]   = (phase < 4) ? (($urandom % 4) != 0) : 1'b0;
      in_pl[s] = rand_pl(s);
    end
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      in_pl[s] = '0; head[s] = 0; occ[s] = 0; used[s] = 0;
      last[s] = '0; exp_v[s] = 0; v_tag[s] = "R10";
    end
    repeat (4) @(negedge clk);
    // R10: reset state, outputs idle, ready with empty queues and full budget
    for (int s = 0; s < 4; s++) begin
      check(obs_v(s) == 1'b0, "R10", "valid in reset", PW'(obs_v(s)), '0);
      check(obs_pl(s) == '0, "R10", "payload in reset", obs_pl(s), '0);
      check(obs_rdy(s) == 1'b1, "R10", "ready in reset", PW'(obs_rdy(s)), PW'(1));
    end
    rst_n = 1'b1;
    for (int c = 0; c < CYCLES + 30; c++) begin
      @(negedge clk);
      compare_outputs();
      drive((c < CYCLES) ? c / (CYCLES / 4) : 4);
      #1;
      step_model();
    end
    @(negedge clk);
    compare_outputs();
    // R5: every accepted request has left the queue
    for (int s = 0; s < 4; s++)
      check(occ[s] == 0, "R5", $sformatf("drained s%0d", s), PW'(occ[s]), '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule